// File: doc/BRIEF.md
# Single-Trit Two-Phase Transfer Calculator

This block is a one-trit balanced-ternary calculator. It holds four one-trit registers, an internal one-trit transfer buffer and a sign flag. A two-trit command (a high trit and a low trit) comes straight from external switches. There is no program store and no instruction pointer: whatever command is present is the one that runs.

Each command runs over one cycle of a three-level phase input, which a system clock samples. The negative level reads the selected source register into the buffer. The positive level writes the buffer into the selected destination register. The zero level does nothing.

When the high trit is zero, the path from the buffer to the register passes through a ternary half adder. The adder adds the low trit to the value, and the carry is dropped. This gives increment, decrement and test on the first register. The same commands also load the sign flag.

Top module: `trit_xfer_calc`

## Requirements
- R1: A synchronous active-high reset clears all four registers, the buffer and the flag to zero.
- R2: Trits use two bits: 2'b00 is zero, 2'b01 is +1 and 2'b11 is -1. The code 2'b10 on any trit input (command or phase) is treated as zero.
- R3: On a clock edge where the phase is -1, the buffer loads the source register. No register and no flag changes.
- R4: On a clock edge where the phase is +1, the destination register is written from the buffer and the buffer keeps its value. Holding +1 for several edges therefore gives the same result as one edge.
- R5: The command selects the source and destination registers:
  - High -1 copies register 1 to register 4, 3 or 2 for low -1, 0 or +1.
  - High +1 copies register 2, 3 or 4 to register 1 for low -1, 0 or +1.
  - The flag is left unchanged by these copy commands.
- R6: With high 0, register 1 is both the source and the destination. It receives buffer plus low, with the sum wrapped: +1 plus +1 gives -1, and -1 plus -1 gives +1.
- R7: With high 0, the flag is set on the store edge to the trit written to register 1.
- R8: A phase of 0 changes no register and no flag, whatever the command is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the phase level |
| rst | input | 1 | Synchronous active-high reset |
| cmd_hi | input | 2 | High command trit |
| cmd_lo | input | 2 | Low command trit |
| phase | input | 2 | Three-level phase trit: -1 load, +1 store, 0 idle |
| reg1_q | output | 2 | Register 1 |
| reg2_q | output | 2 | Register 2 |
| reg3_q | output | 2 | Register 3 |
| reg4_q | output | 2 | Register 4 |
| flag_q | output | 2 | Sign flag |

## Verification
The bench runs every one of the nine commands. The copy values are built up with increments, so each copy moves a value that differs from the destination's old content. This separates a wrong source or destination select from a correct one. Increment and decrement are pushed past both ends of the trit range to expose missing wrap-around. Copies are placed after adjust commands so that a flag that wrongly tracks copies is caught.

Further sequences probe the timing of the phases and the input codes:
- A store level held for three edges on an increment separates a held buffer from one that reloads.
- A load-only cycle and long idle runs show that nothing is written outside the store phase.
- The unused code 2'b10 on the phase and on the high command trit shows that it decodes as zero.

// File: rtl/trit_calc_pkg.sv
package trit_calc_pkg;

    localparam int TRIT_W  = 2;
    localparam int REG_CNT = 4;
    localparam int SEL_W   = $clog2(REG_CNT);

    typedef logic [TRIT_W-1:0] trit_t;

    localparam trit_t T_ZERO = 2'b00;
    localparam trit_t T_POS  = 2'b01;
    localparam trit_t T_NEG  = 2'b11;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOAD  = 2'd1,
        PH_STORE = 2'd2
    } phase_e;

    typedef struct packed {
        logic [SEL_W-1:0] src_sel;
        logic [SEL_W-1:0] dst_sel;
        logic             adjust;
        trit_t            addend;
    } cmd_dec_t;

    // map the unused code onto zero
    function automatic trit_t trit_norm(input trit_t t);
        return (t == 2'b10) ? T_ZERO : t;
    endfunction

    function automatic phase_e phase_of(input trit_t t);
        case (trit_norm(t))
            T_NEG:   return PH_LOAD;
            T_POS:   return PH_STORE;
            default: return PH_IDLE;
        endcase
    endfunction

    function automatic logic signed [2:0] trit_val(input trit_t t);
        case (trit_norm(t))
            T_POS:   return 3'sd1;
            T_NEG:   return -3'sd1;
            default: return 3'sd0;
        endcase
    endfunction

    function automatic trit_t trit_enc(input logic signed [2:0] v);
        case (v)
            3'sd1:   return T_POS;
            -3'sd1:  return T_NEG;
            default: return T_ZERO;
        endcase
    endfunction

    // half adder sum digit, carry dropped
    function automatic trit_t trit_half_sum(input trit_t a, input trit_t b);
        logic signed [2:0] s;
        s = trit_val(a) + trit_val(b);
        if (s > 3'sd1)
            s = s - 3'sd3;
        else if (s < -3'sd1)
            s = s + 3'sd3;
        return trit_enc(s);
    endfunction

endpackage

// File: rtl/calc_cmd_decode.sv
module calc_cmd_decode
    import trit_calc_pkg::*;
(
    input  trit_t    cmd_hi,
    input  trit_t    cmd_lo,
    output cmd_dec_t dec
);

    trit_t hi_n;
    trit_t lo_n;
    logic [SEL_W-1:0] lo_idx;

    assign hi_n = trit_norm(cmd_hi);
    assign lo_n = trit_norm(cmd_lo);

    // low trit as 1..3 for -1, 0, +1
    always_comb begin
        case (lo_n)
            T_NEG:   lo_idx = SEL_W'(1);
            T_POS:   lo_idx = SEL_W'(3);
            default: lo_idx = SEL_W'(2);
        endcase
    end

    always_comb begin
        dec.src_sel = '0;
        dec.dst_sel = '0;
        dec.adjust  = 1'b0;
        dec.addend  = lo_n;
        case (hi_n)
            T_NEG: begin
                // register 1 out to 4, 3, 2
                dec.dst_sel = SEL_W'(4) - lo_idx;
            end
            T_POS: begin
                dec.src_sel = lo_idx;
            end
            default: begin
                dec.adjust = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/calc_regfile.sv
module calc_regfile
    import trit_calc_pkg::*;
#(
    parameter int NREG = REG_CNT,
    localparam int SW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [SW-1:0]              rd_sel,
    output trit_t                      rd_data,
    input  logic                       wr_en,
    input  logic [SW-1:0]              wr_sel,
    input  trit_t                      wr_data,
    output logic [NREG-1:0][TRIT_W-1:0] regs_q
);

    for (genvar g = 0; g < NREG; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[g] <= T_ZERO;
            else if (wr_en && (wr_sel == SW'(g)))
                regs_q[g] <= wr_data;
        end
    end

    assign rd_data = regs_q[rd_sel];

    a_r8_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs_q));

    a_r4_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> regs_q[$past(wr_sel)] == $past(wr_data));

endmodule

// File: rtl/calc_datapath.sv
module calc_datapath
    import trit_calc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  phase_e   ph,
    input  cmd_dec_t dec,
    input  trit_t    rd_data,
    output logic     wr_en,
    output trit_t    wr_data,
    output trit_t    flag_q
);

    trit_t buf_q;
    trit_t sum;

    always_ff @(posedge clk) begin
        if (rst)
            buf_q <= T_ZERO;
        else if (ph == PH_LOAD)
            buf_q <= rd_data;
    end

    assign sum     = trit_half_sum(buf_q, dec.addend);
    assign wr_data = dec.adjust ? sum : buf_q;
    assign wr_en   = (ph == PH_STORE);

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= T_ZERO;
        else if (wr_en && dec.adjust)
            flag_q <= sum;
    end

    a_r3_buffer_loads: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_LOAD) |=> buf_q == $past(rd_data));

    a_r4_buffer_holds: assert property (@(posedge clk) disable iff (rst)
        (ph != PH_LOAD) |=> $stable(buf_q));

    a_r7_flag_only_on_adjust: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && dec.adjust) |=> $stable(flag_q));

endmodule

// File: rtl/trit_xfer_calc.sv
module trit_xfer_calc
    import trit_calc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cmd_hi,
    input  logic [1:0] cmd_lo,
    input  logic [1:0] phase,
    output logic [1:0] reg1_q,
    output logic [1:0] reg2_q,
    output logic [1:0] reg3_q,
    output logic [1:0] reg4_q,
    output logic [1:0] flag_q
);

    phase_e   ph;
    cmd_dec_t dec;
    trit_t    rd_data;
    trit_t    wr_data;
    trit_t    flag_w;
    logic     wr_en;
    logic [REG_CNT-1:0][TRIT_W-1:0] regs;

    assign ph = phase_of(phase);

    calc_cmd_decode u_decode (
        .cmd_hi (cmd_hi),
        .cmd_lo (cmd_lo),
        .dec    (dec)
    );

    calc_regfile #(.NREG(REG_CNT)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .rd_sel  (dec.src_sel),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_sel  (dec.dst_sel),
        .wr_data (wr_data),
        .regs_q  (regs)
    );

    calc_datapath u_path (
        .clk     (clk),
        .rst     (rst),
        .ph      (ph),
        .dec     (dec),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .flag_q  (flag_w)
    );

    assign reg1_q = regs[0];
    assign reg2_q = regs[1];
    assign reg3_q = regs[2];
    assign reg4_q = regs[3];
    assign flag_q = flag_w;

    a_r7_flag_tracks_r1: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_STORE && trit_norm(cmd_hi) == T_ZERO) |=> flag_q == reg1_q);

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_IDLE) |=> ($stable(regs) && $stable(flag_q)));

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (regs == '0 && flag_q == T_ZERO));

endmodule

// File: tb/trit_xfer_calc_tb.sv
`timescale 1ns/1ps
module trit_xfer_calc_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] cmd_hi = 2'b00;
    logic [1:0] cmd_lo = 2'b00;
    logic [1:0] phase  = 2'b00;
    logic [1:0] reg1_q, reg2_q, reg3_q, reg4_q, flag_q;

    always #10 clk = ~clk;

    trit_xfer_calc u_dut (
        .clk(clk), .rst(rst), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo), .phase(phase),
        .reg1_q(reg1_q), .reg2_q(reg2_q), .reg3_q(reg3_q), .reg4_q(reg4_q),
        .flag_q(flag_q)
    );

    typedef struct {
        int    r[4];
        int    f;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    event mon_ev;
    int checks = 0;
    int failures = 0;
    int m[4];
    int mflag;
    int mbuf;

    function automatic int t2i(logic [1:0] t);
        return (t == 2'b01) ? 1 : (t == 2'b11) ? -1 : 0;
    endfunction

    function automatic int wrap(int s);
        if (s > 1) return s - 3;
        if (s < -1) return s + 3;
        return s;
    endfunction

    task automatic cmp(string tag, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // monitor: pop expected state and compare with outputs
    always begin
        @(mon_ev);
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            cmp(e.tag, "reg1", t2i(reg1_q), e.r[0]);
            cmp(e.tag, "reg2", t2i(reg2_q), e.r[1]);
            cmp(e.tag, "reg3", t2i(reg3_q), e.r[2]);
            cmp(e.tag, "reg4", t2i(reg4_q), e.r[3]);
            cmp(e.tag, "flag", t2i(flag_q), e.f);
        end
    end

    task automatic push_exp(string tag);
        exp_t e;
        for (int k = 0; k < 4; k++) e.r[k] = m[k];
        e.f = mflag;
        e.tag = tag;
        exp_q.push_back(e);
        -> mon_ev;
        #1;
    endtask

    // drive one command: one load edge, npos store edges, then idle
    task automatic do_cmd(logic [1:0] hi, logic [1:0] lo, int npos, string tag);
        int h, l, src, dst;
        h = t2i(hi);
        l = t2i(lo);
        cmd_hi = hi;
        cmd_lo = lo;
        phase = 2'b11;
        @(negedge clk);
        if (h < 0) begin src = 0; dst = 2 - l; end
        else if (h > 0) begin src = 2 + l; dst = 0; end
        else begin src = 0; dst = 0; end
        mbuf = m[src];
        for (int p = 0; p < npos; p++) begin
            phase = 2'b01;
            @(negedge clk);
            if (h == 0) begin
                m[0] = wrap(mbuf + l);
                mflag = m[0];
            end else begin
                m[dst] = mbuf;
            end
        end
        phase = 2'b00;
        push_exp(tag);
    endtask

    task automatic idle_run(logic [1:0] ph, logic [1:0] hi, logic [1:0] lo, int n, string tag);
        cmd_hi = hi;
        cmd_lo = lo;
        phase = ph;
        repeat (n) @(negedge clk);
        phase = 2'b00;
        push_exp(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) m[k] = 0;
        mflag = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        push_exp("R1_reset");

        do_cmd(2'b00, 2'b01, 1, "R6_inc_zero");      // r1 = +1
        do_cmd(2'b11, 2'b01, 1, "R5_r1_to_r2");      // r2 = +1
        do_cmd(2'b00, 2'b01, 1, "R6_inc_wrap_pos");  // r1 = -1
        do_cmd(2'b11, 2'b00, 1, "R5_r1_to_r3");      // r3 = -1
        do_cmd(2'b00, 2'b01, 1, "R6_inc_to_zero");   // r1 = 0
        do_cmd(2'b00, 2'b11, 1, "R6_dec_zero");      // r1 = -1
        do_cmd(2'b11, 2'b11, 1, "R5_r1_to_r4");      // r4 = -1
        do_cmd(2'b00, 2'b11, 1, "R6_dec_wrap_neg");  // r1 = +1
        do_cmd(2'b01, 2'b00, 1, "R5_R7_r3_to_r1");   // r1 = -1, flag kept
        do_cmd(2'b01, 2'b11, 1, "R5_r2_to_r1");      // r1 = +1
        do_cmd(2'b01, 2'b01, 1, "R5_r4_to_r1");      // r1 = -1
        do_cmd(2'b00, 2'b00, 1, "R7_test_r1");       // flag = -1
        do_cmd(2'b00, 2'b01, 3, "R4_held_store");    // r1 = 0 once
        do_cmd(2'b01, 2'b11, 0, "R3_load_only");
        idle_run(2'b00, 2'b00, 2'b01, 5, "R8_idle_inc");
        idle_run(2'b00, 2'b11, 2'b11, 4, "R8_idle_copy");
        idle_run(2'b10, 2'b00, 2'b01, 4, "R2_bad_phase_idle");
        do_cmd(2'b10, 2'b01, 1, "R2_bad_hi_as_zero"); // r1 = +1
        do_cmd(2'b01, 2'b10, 1, "R2_bad_lo_as_zero"); // r3 to r1 = -1
        do_cmd(2'b11, 2'b01, 2, "R4_held_copy");      // r2 = -1

        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule